// File: doc/BRIEF.md
# Drive Bay Interface Isolation Controller

This block lets a parallel storage drive sit in a bay that can be emptied and refilled while the rest of the system keeps running. It manages two storage channels. For each channel it holds a bit that chooses what the channel's pads do while that channel is held in reset. The bit can either float the pads or drive them low. A write-once lock protects both bits from later software. The block also turns the channel's reset state and that bit into pad controls: output enable, drive-low and input-buffer enable. It reports the resulting 2-bit signal mode for each channel through a read-only register.

One channel (parameter `BAY_CH`, the secondary channel by default) connects to the removable bay. A small sequencer owns the bay's own power-enable and reset outputs. A removal request puts the drive in reset, then floats its bus, then cuts power. An insertion request first drives the bus to its default low levels. Only then does it apply power. It waits a programmable settle count, releases the drive reset, and finally releases the channel. A drive that is powering up therefore never sees a floating bus, so it cannot latch a test-mode strap. The register port, the requests and the pad controls are plain level signals with no handshake. A write takes effect on the clock edge where `reg_wr` is high, and read data follows `reg_addr` combinationally.

Top module: `bay_iso_ctrl`

## Requirements
- R1: After platform reset (`rst_n` low) both tri-state enables are 1, the lock is 0, all IORDY sample enables are 0, the settle count is `SETTLE_DEF` (4), the sequencer is in state OFF (code 0) and the error flag is 0.
- R2: Register 0 (CTRL) holds the tri-state enable of channel c in bit c (bits 1:0). A write to it updates these bits while the lock is 0, and a read returns them.
- R3: CTRL bit 2 is the lock. Writing 1 sets it. Writing 0 never clears it, and only `rst_n` returns it to 0.
- R4: While the lock is 1, writes to CTRL leave both tri-state enables unchanged.
- R5: A channel in reset with its enable at 1 floats its pads: `pad_oe`=0, `pad_drv_low`=0, `pad_ibe`=0, and its mode field reads 01.
- R6: A channel in reset with its enable at 0 drives low: `pad_oe`=1, `pad_drv_low`=1, `pad_ibe`=0, and its mode field reads 10.
- R7: A channel out of reset runs normally (`pad_oe`=1, `pad_drv_low`=0, `pad_ibe`=1, mode 00). Register 2 (MODE, read-only) holds channel 0's mode in bits 1:0 and channel 1's in bits 3:2. A channel is in reset when its `chan_rst_req` bit is high, or when it is the bay channel and the sequencer is outside ACTIVE.
- R8: `swap_out_req` in ACTIVE (4) starts removal. The next cycle is RM_RST (5): bay reset on, power on, normal reset rule. Then comes RM_TRI (6): bay pads forced to float, power still on. Then comes OFF (0): power off, bay reset on, pads floating.
- R9: `swap_in_req` in OFF starts insertion. IN_DRV (1) lasts one cycle, with bay pads driven low and power off. IN_PWR (2) follows, with power on, and lasts S+1 cycles, where S is register 1 (SETTLE) as it stands when IN_PWR is entered. IN_REL (3) lasts one cycle, with bay reset released and the channel still held. Then comes ACTIVE.
- R10: Whenever bay power rises, the bay channel pads are driving low both in that cycle and in the cycle before.
- R11: Register 3 (STATUS, read-only) returns the state code in bits 2:0 and busy in bit 3. Busy is 1 in every state except OFF and ACTIVE.
- R12: A swap request that the current state does not accept sets the error flag (STATUS bit 4) and leaves the sequence unchanged. This covers any request while busy, removal in OFF and insertion in ACTIVE. The flag stays set until `rst_n`.
- R13: CTRL bits 6:3 are the IORDY sample enables, with bit 3+2c+d for drive d of channel c. They drive `iordy_en` and stay writable while the lock is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Platform reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| chan_rst_req | input | 2 | Per-channel reset request |
| swap_out_req | input | 1 | Bay removal request |
| swap_in_req | input | 1 | Bay insertion request |
| pad_oe | output | 2 | Per-channel pad output enable |
| pad_drv_low | output | 2 | Per-channel pad force-low |
| pad_ibe | output | 2 | Per-channel input-buffer enable |
| chan_rst | output | 2 | Effective per-channel reset |
| bay_pwr_en | output | 1 | Bay supply switch enable |
| bay_rst | output | 1 | Bay drive reset |
| iordy_en | output | 4 | IORDY sample enables |

## Verification
The bench goes after the lock. It writes the lock together with new enables in the same write, tries to clear the lock with a zero write, and checks that only `rst_n` clears it. A design that applied the lock one write early, or let software clear it, would show different CTRL and pad values. The bench runs insertion with a settle count of 3 and again with 0, counting each cycle in IN_PWR. An off-by-one counter, or a design that applies power before driving the bus low, shows up as a mismatched `bay_pwr_en` or pad cycle. It also sends requests mid-sequence and in the wrong idle state, and sets channel resets while the bay is ACTIVE. A design that queued the stray requests, or lost the sticky error, would take a different state path.

// File: rtl/bay_pkg.sv
package bay_pkg;
  localparam int NCH = 2;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_IN_DRV = 3'd1,
    ST_IN_PWR = 3'd2,
    ST_IN_REL = 3'd3,
    ST_ACTIVE = 3'd4,
    ST_RM_RST = 3'd5,
    ST_RM_TRI = 3'd6
  } seq_st_t;

  localparam logic [1:0] MODE_RUN = 2'b00;
  localparam logic [1:0] MODE_TRI = 2'b01;
  localparam logic [1:0] MODE_LOW = 2'b10;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_SETTLE = 2'd1;
  localparam logic [1:0] A_MODE   = 2'd2;
  localparam logic [1:0] A_STAT   = 2'd3;
endpackage

// File: rtl/bay_regs.sv
module bay_regs
  import bay_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SETTLE_DEF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NCH-1:0]    tri_en,
  output logic              lock,
  output logic [2*NCH-1:0]  iordy,
  output logic [DATA_W-1:0] settle
);
  localparam int LOCK_BIT = NCH;
  localparam int IO_LSB   = NCH + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tri_en <= '1;
      lock   <= 1'b0;
      iordy  <= '0;
      settle <= DATA_W'(SETTLE_DEF);
    end else if (wr) begin
      if (addr == A_CTRL) begin
        if (!lock) tri_en <= wdata[NCH-1:0];
        if (wdata[LOCK_BIT]) lock <= 1'b1;
        iordy <= wdata[IO_LSB +: 2*NCH];
      end
      if (addr == A_SETTLE) settle <= wdata;
    end
  end

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  // R4
  tri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr && addr == A_CTRL) |=> tri_en == $past(tri_en));
endmodule

// File: rtl/bay_seq.sv
module bay_seq
  import bay_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_req,
  input  logic             in_req,
  input  logic [CNT_W-1:0] settle,
  output seq_st_t          st,
  output logic             busy,
  output logic             err,
  output logic             bay_pwr,
  output logic             bay_rst,
  output logic             hold,
  output logic             force_tri,
  output logic             force_low
);
  seq_st_t          nxt;
  logic [CNT_W-1:0] cnt;
  logic             acc_in, acc_out, rej;

  assign acc_in  = in_req  && (st == ST_OFF);
  assign acc_out = out_req && (st == ST_ACTIVE);
  assign rej     = (in_req && !acc_in) || (out_req && !acc_out);
  assign busy    = (st != ST_OFF) && (st != ST_ACTIVE);

  always_comb begin
    nxt = st;
    case (st)
      ST_OFF:    if (acc_in) nxt = ST_IN_DRV;
      ST_IN_DRV: nxt = ST_IN_PWR;
      ST_IN_PWR: if (cnt == '0) nxt = ST_IN_REL;
      ST_IN_REL: nxt = ST_ACTIVE;
      ST_ACTIVE: if (acc_out) nxt = ST_RM_RST;
      ST_RM_RST: nxt = ST_RM_TRI;
      ST_RM_TRI: nxt = ST_OFF;
      default:   nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_OFF;
      cnt <= '0;
      err <= 1'b0;
    end else begin
      st  <= nxt;
      err <= err | rej;
      if (st == ST_IN_DRV) cnt <= settle;
      else if (st == ST_IN_PWR && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    bay_pwr   = 1'b1;
    bay_rst   = 1'b1;
    hold      = 1'b1;
    force_tri = 1'b0;
    force_low = 1'b0;
    case (st)
      ST_OFF:    begin bay_pwr = 1'b0; force_tri = 1'b1; end
      ST_IN_DRV: begin bay_pwr = 1'b0; force_low = 1'b1; end
      ST_IN_PWR: force_low = 1'b1;
      ST_IN_REL: begin bay_rst = 1'b0; force_low = 1'b1; end
      ST_ACTIVE: begin bay_rst = 1'b0; hold = 1'b0; end
      ST_RM_TRI: force_tri = 1'b1;
      default:   ;
    endcase
  end

  // R8
  rm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bay_pwr) |-> $past(bay_rst) && $past(force_tri));
  // R9
  rel_after_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bay_rst) |-> bay_pwr && $past(bay_pwr));
  // R12
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (in_req || out_req)) |=> err && st != ST_RM_RST && st != ST_IN_DRV);
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/bay_pad.sv
module bay_pad
  import bay_pkg::*;
#(
  parameter bit IS_BAY = 1'b0
) (
  input  logic       rst_req,
  input  logic       tri_en,
  input  logic       hold,
  input  logic       force_tri,
  input  logic       force_low,
  output logic       oe,
  output logic       drv_low,
  output logic       ibe,
  output logic       in_rst,
  output logic [1:0] mode
);
  logic f_low, f_tri;

  assign f_low  = IS_BAY && force_low;
  assign f_tri  = IS_BAY && force_tri;
  assign in_rst = rst_req || (IS_BAY && hold);

  always_comb begin
    if (f_low || (in_rst && !f_tri && !tri_en)) begin
      {oe, drv_low, ibe} = 3'b110;
      mode = MODE_LOW;
    end else if (f_tri || in_rst) begin
      {oe, drv_low, ibe} = 3'b000;
      mode = MODE_TRI;
    end else begin
      {oe, drv_low, ibe} = 3'b101;
      mode = MODE_RUN;
    end
  end
endmodule

// File: rtl/bay_iso_ctrl.sv
module bay_iso_ctrl
  import bay_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SETTLE_DEF = 4,
  parameter int BAY_CH     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    chan_rst_req,
  input  logic              swap_out_req,
  input  logic              swap_in_req,
  output logic [NCH-1:0]    pad_oe,
  output logic [NCH-1:0]    pad_drv_low,
  output logic [NCH-1:0]    pad_ibe,
  output logic [NCH-1:0]    chan_rst,
  output logic              bay_pwr_en,
  output logic              bay_rst,
  output logic [2*NCH-1:0]  iordy_en
);
  localparam int CTRL_W = 3*NCH + 1;

  logic [NCH-1:0]    tri_en;
  logic              lock;
  logic [DATA_W-1:0] settle;
  seq_st_t           st;
  logic              busy, err, hold, force_tri, force_low;
  logic [2*NCH-1:0]  mode_all;

  bay_regs #(.DATA_W(DATA_W), .SETTLE_DEF(SETTLE_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .tri_en(tri_en), .lock(lock), .iordy(iordy_en), .settle(settle)
  );

  bay_seq #(.CNT_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .out_req(swap_out_req), .in_req(swap_in_req),
    .settle(settle), .st(st), .busy(busy), .err(err), .bay_pwr(bay_pwr_en),
    .bay_rst(bay_rst), .hold(hold), .force_tri(force_tri), .force_low(force_low)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_pad
    bay_pad #(.IS_BAY(c == BAY_CH)) u_pad (
      .rst_req(chan_rst_req[c]), .tri_en(tri_en[c]), .hold(hold),
      .force_tri(force_tri), .force_low(force_low),
      .oe(pad_oe[c]), .drv_low(pad_drv_low[c]), .ibe(pad_ibe[c]),
      .in_rst(chan_rst[c]), .mode(mode_all[2*c +: 2])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata[CTRL_W-1:0] = {iordy_en, lock, tri_en};
      A_SETTLE: reg_rdata = settle;
      A_MODE:   reg_rdata[2*NCH-1:0] = mode_all;
      default:  reg_rdata[4:0] = {err, busy, st};
    endcase
  end

  // R10
  pwr_up_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bay_pwr_en) |-> pad_oe[BAY_CH] && pad_drv_low[BAY_CH]
                          && $past(pad_oe[BAY_CH] && pad_drv_low[BAY_CH]));
  // R6
  no_float_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_drv_low & ~pad_oe) == '0);
  // R5
  ibe_off_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_ibe & chan_rst) == '0);
endmodule

// File: tb/bay_iso_ctrl_test.sv
module bay_iso_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] chan_rst_req = 2'b00;
  logic       swap_out_req = 1'b0;
  logic       swap_in_req = 1'b0;
  logic [1:0] pad_oe, pad_drv_low, pad_ibe, chan_rst;
  logic       bay_pwr_en, bay_rst;
  logic [3:0] iordy_en;

  int n_chk = 0;
  int n_fail = 0;
  int rot = 0;

  // reference model state
  int       m_st, m_cnt;
  bit [1:0] m_tri;
  bit       m_lock, m_err;
  bit [3:0] m_io;
  bit [7:0] m_set;

  bay_iso_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_rst_req(chan_rst_req),
    .swap_out_req(swap_out_req), .swap_in_req(swap_in_req), .pad_oe(pad_oe),
    .pad_drv_low(pad_drv_low), .pad_ibe(pad_ibe), .chan_rst(chan_rst),
    .bay_pwr_en(bay_pwr_en), .bay_rst(bay_rst), .iordy_en(iordy_en)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual=%0h expected=%0h", tag, what, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_tri = 2'b11; m_lock = 0; m_err = 0; m_io = 0; m_set = 8'd4;
  endtask

  // Expected per-channel pad behaviour from the requirements
  task automatic exp_pad(input int c, output bit oe, output bit lo, output bit ib,
                         output bit rs, output bit [1:0] md);
    bit held, flow, ftri;
    held = (c == 1) && (m_st != 4);
    flow = (c == 1) && (m_st == 1 || m_st == 2 || m_st == 3);
    ftri = (c == 1) && (m_st == 0 || m_st == 6);
    rs = chan_rst_req[c] || held;
    if (flow || (rs && !ftri && !m_tri[c])) begin oe = 1; lo = 1; ib = 0; md = 2'b10; end
    else if (ftri || rs)                    begin oe = 0; lo = 0; ib = 0; md = 2'b01; end
    else                                    begin oe = 1; lo = 0; ib = 1; md = 2'b00; end
  endtask

  task automatic compare();
    bit oe, lo, ib, rs;
    bit [1:0] md;
    bit [1:0] modes;
    bit [7:0] er;
    string t;
    bit busy;
    for (int c = 0; c < 2; c++) begin
      exp_pad(c, oe, lo, ib, rs, md);
      modes[c] = 1'b0;
      if (md == 2'b01) t = "R5"; else if (md == 2'b10) t = "R6"; else t = "R7";
      if (!rst_n) t = "R1";
      chk(t, $sformatf("pad_oe[%0d]", c), int'(pad_oe[c]), int'(oe));
      chk(t, $sformatf("pad_drv_low[%0d]", c), int'(pad_drv_low[c]), int'(lo));
      chk(t, $sformatf("pad_ibe[%0d]", c), int'(pad_ibe[c]), int'(ib));
      chk("R7", $sformatf("chan_rst[%0d]", c), int'(chan_rst[c]), int'(rs));
    end
    t = (m_st >= 5 || m_st == 0) ? "R8" : "R9";
    chk(t, "bay_pwr_en", int'(bay_pwr_en), (m_st >= 2) ? 1 : 0);
    chk(t, "bay_rst", int'(bay_rst), (m_st == 3 || m_st == 4) ? 0 : 1);
    chk("R13", "iordy_en", int'(iordy_en), int'(m_io));
    busy = (m_st != 0 && m_st != 4);
    case (reg_addr)
      2'd0: begin er = {1'b0, m_io, m_lock, m_tri}; t = "R2 R3 R4"; end
      2'd1: begin er = m_set; t = "R9"; end
      2'd2: begin
        exp_pad(0, oe, lo, ib, rs, md); er[1:0] = md;
        exp_pad(1, oe, lo, ib, rs, md); er[3:2] = md; er[7:4] = 0; t = "R7";
      end
      default: begin er = {3'b0, m_err, busy, 3'(m_st)}; t = "R11 R12"; end
    endcase
    if (!rst_n) t = "R1";
    chk(t, $sformatf("reg_rdata@%0d", reg_addr), int'(reg_rdata), int'(er));
    modes = 0;
  endtask

  task automatic model_step();
    bit acc_in, acc_out;
    int st0;
    if (!rst_n) begin model_reset(); return; end
    st0 = m_st;
    acc_in  = swap_in_req && st0 == 0;
    acc_out = swap_out_req && st0 == 4;
    if ((swap_in_req && !acc_in) || (swap_out_req && !acc_out)) m_err = 1;
    case (st0)
      0: if (acc_in) m_st = 1;
      1: begin m_st = 2; m_cnt = m_set; end
      2: if (m_cnt == 0) m_st = 3; else m_cnt--;
      3: m_st = 4;
      4: if (acc_out) m_st = 5;
      5: m_st = 6;
      default: m_st = 0;
    endcase
    if (reg_wr && reg_addr == 2'd0) begin
      if (!m_lock) m_tri = reg_wdata[1:0];
      if (reg_wdata[2]) m_lock = 1;
      m_io = reg_wdata[6:3];
    end
    if (reg_wr && reg_addr == 2'd1) m_set = reg_wdata;
  endtask

  // one clock: check mid-low phase, step the model at the edge
  task automatic cyc();
    #5;
    if (!rst_n) model_reset();
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      reg_wr = 0; reg_addr = 2'(rot); rot++;
      cyc();
    end
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 0;
  endtask

  task automatic pulse_in();  swap_in_req = 1;  reg_addr = 2'd3; cyc(); swap_in_req = 0;  endtask
  task automatic pulse_out(); swap_out_req = 1; reg_addr = 2'd3; cyc(); swap_out_req = 0; endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    rst_n = 0; idle(3);                 // R1 reset values
    rst_n = 1; idle(4);                 // R1 after release
    wr(2'd1, 8'd3);                     // R9 settle = 3
    chan_rst_req = 2'b01; idle(4);      // R5 channel 0 floats
    wr(2'd0, 8'h02);                    // R2 channel 0 enable off
    idle(4);                            // R6 channel 0 drives low
    chan_rst_req = 2'b00; idle(2);      // R7
    wr(2'd0, 8'h7B);                    // R2 R13 enables on, iordy all 1
    pulse_in(); idle(2);                // R9 insertion
    pulse_out();                        // R12 rejected while busy
    idle(8);
    chan_rst_req = 2'b10; idle(3);      // R5 bay channel in reset while ACTIVE
    wr(2'd0, 8'h79); idle(2);           // R6 bay channel enable off
    chan_rst_req = 2'b00; wr(2'd0, 8'h7B);
    pulse_out(); idle(5);               // R8 removal
    wr(2'd1, 8'd0);
    pulse_in(); idle(6);                // R9 zero settle
    pulse_in(); idle(2);                // R12 insertion in ACTIVE
    wr(2'd0, 8'h04);                    // R3 lock set, enables written to 00
    wr(2'd0, 8'h1B);                    // R4 enables stay 00, R13 iordy still written
    wr(2'd0, 8'h00);                    // R3 zero write keeps lock
    chan_rst_req = 2'b01; idle(4);      // R6 while locked
    chan_rst_req = 2'b00;
    rst_n = 0; idle(2);                 // R1 R3 only reset clears lock
    rst_n = 1; idle(4);
    wr(2'd0, 8'h01); idle(4);           // R2 unlocked again
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule